// File: doc/BRIEF.md
# Signature Port Write Decoder

This block snoops a plain memory write bus and reacts only to stores aimed at one fixed signature address. Software running on the core under test uses that address as a message channel: each message begins with a header word whose lowest byte names its kind. The block turns those words into single-cycle event strobes for the rest of the test environment. The events are a core-status update, a pass/fail verdict, a walk through all 32 general registers, and a CSR address with its value.

Two of the message kinds span several words. A register dump is a header followed by 32 data words. A CSR transfer is a header carrying the CSR address followed by one data word. The block keeps the sequencing state for these messages. While payload is outstanding, every matching store is taken as data, whatever its bit pattern. Headers with an unknown kind, and status headers with an out-of-range code, raise a one-cycle error pulse and leave the decoder waiting for a new header.

Top module: `sig_write_decoder`

## Requirements
- R1: `rst_n` is a synchronous active-low reset. While it is low at a clock edge, all strobes are cleared after that edge and the decoder returns to waiting for a header, even in the middle of a multi-word message.
- R2: A header with bits [7:0] = 0 is a status message. If bits [12:8] hold a code from 0 to 13, `status_vld` pulses with `status_code` equal to that code.
- R3: A header with bits [7:0] = 1 is a verdict message. `result_vld` pulses, and `result_fail` equals bit 8 of the word (0 = pass, 1 = fail).
- R4: A header with bits [7:0] = 2 starts a register dump. Each of the next 32 matching stores gives a `dump_vld` pulse carrying the word on `dump_data` and an index on `dump_idx` that counts 0 through 31.
- R5: `dump_done` pulses together with the `dump_vld` of index 31, and the decoder then expects a header again.
- R6: A header with bits [7:0] = 3 carries a CSR address in bits [19:8]. The next matching store gives a `csr_vld` pulse with `csr_addr` equal to that address and `csr_data` equal to the store's data.
- R7: A header whose bits [7:0] are any value from 4 to 255 gives an `err_pulse` and no other event. The decoder stays waiting for a header.
- R8: A status header whose code in bits [12:8] is from 14 to 31 gives an `err_pulse` and no `status_vld`.
- R9: A cycle with `wr_valid` low, or with `wr_addr` not equal to `SIG_ADDR`, produces no strobe and does not advance a pending message.
- R10: While dump or CSR payload is pending, a matching store is used as payload even if its low byte looks like a header, and no header event can occur.
- R11: Every strobe is high for exactly one cycle, in the cycle after the edge that sampled the message's final store. At most one of `status_vld`, `result_vld`, `dump_vld`, `csr_vld` and `err_pulse` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Store present this cycle |
| wr_addr | input | ADDR_W | Store address |
| wr_data | input | DATA_W | Store data |
| status_vld | output | 1 | Status event strobe |
| status_code | output | 5 | Status code (0..13) |
| result_vld | output | 1 | Verdict event strobe |
| result_fail | output | 1 | 1 = fail, 0 = pass |
| dump_vld | output | 1 | One dumped register word |
| dump_idx | output | 5 | Register number of the dumped word |
| dump_data | output | DATA_W | Dumped register value |
| dump_done | output | 1 | Final register of a dump |
| csr_vld | output | 1 | CSR transfer strobe |
| csr_addr | output | 12 | CSR address from the header |
| csr_data | output | DATA_W | CSR value |
| err_pulse | output | 1 | Malformed header seen |

## Verification
The checker assumes that a store is a single-cycle `wr_valid` pulse sampled on the rising edge. It also assumes that `wr_addr` and `wr_data` are meaningful only while `wr_valid` is high, and that `DATA_W` is at least 20 so the CSR field fits. The bench changes inputs only on the falling edge and holds each store for exactly one cycle. It mixes matching stores with stores to a neighbouring address and with idle cycles. Its random phase draws header bytes from a small range, so legal kinds, illegal kinds and payload words that resemble headers all appear.

// File: rtl/sigdec_pkg.sv
// Shared constants and types of the signature write decoder.
// Assumes the header layout: kind byte in [7:0], fields starting at bit 8.
package sigdec_pkg;
    localparam int KIND_W      = 8;
    localparam int CODE_LSB    = 8;
    localparam int CODE_W      = 5;
    localparam int CSR_AW      = 12;
    localparam int HDR_USED_W  = CODE_LSB + CSR_AW;
    localparam int STATUS_CNT  = 14;
    localparam int NUM_REGS    = 32;
    localparam int IDX_W       = $clog2(NUM_REGS);

    localparam logic [KIND_W-1:0] KIND_STATUS = 8'd0;
    localparam logic [KIND_W-1:0] KIND_RESULT = 8'd1;
    localparam logic [KIND_W-1:0] KIND_DUMP   = 8'd2;
    localparam logic [KIND_W-1:0] KIND_CSR    = 8'd3;

    typedef enum logic [2:0] {
        HK_STATUS,
        HK_RESULT,
        HK_DUMP,
        HK_CSR,
        HK_BAD
    } hdr_kind_e;

    typedef enum logic [1:0] {
        SQ_HEADER,
        SQ_DUMP,
        SQ_CSR
    } seq_state_e;
endpackage

// File: rtl/sigdec_addr_match.sv
// Address filter: flags a store that targets the signature address.
// Assumes one store per cycle, qualified by the valid bit.
module sigdec_addr_match #(
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] SIG_ADDR = '0
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    // Qualify the address compare with the store valid.
    always_comb begin
        hit = valid && (addr == SIG_ADDR);
    end
endmodule

// File: rtl/sigdec_hdr_decode.sv
// Header classifier: maps the low header bits to a message kind and fields.
// Assumes the caller only acts on the result when a header is expected.
module sigdec_hdr_decode
    import sigdec_pkg::*;
(
    input  logic [HDR_USED_W-1:0] hdr,
    output hdr_kind_e             kind,
    output logic [CODE_W-1:0]     code,
    output logic                  fail,
    output logic [CSR_AW-1:0]     csr_addr
);
    logic [KIND_W-1:0] kind_byte;
    logic              code_ok;

    // Slice the fields out of the header word.
    always_comb begin
        kind_byte = hdr[KIND_W-1:0];
        code      = hdr[CODE_LSB +: CODE_W];
        fail      = hdr[CODE_LSB];
        csr_addr  = hdr[CODE_LSB +: CSR_AW];
        code_ok   = (32'(code) < STATUS_CNT);
    end

    // Classify the kind byte, folding illegal status codes into the error kind.
    always_comb begin
        unique case (kind_byte)
            KIND_STATUS: kind = code_ok ? HK_STATUS : HK_BAD;
            KIND_RESULT: kind = HK_RESULT;
            KIND_DUMP:   kind = HK_DUMP;
            KIND_CSR:    kind = HK_CSR;
            default:     kind = HK_BAD;
        endcase
    end
endmodule

// File: rtl/sigdec_seq.sv
// Message sequencer: tracks multi-word messages and registers all events.
// Assumes hit is a one-cycle store qualifier; header fields are only used
// in the header-expecting state.
module sigdec_seq
    import sigdec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [DATA_W-1:0] wr_data,
    input  hdr_kind_e         kind,
    input  logic [CODE_W-1:0] code,
    input  logic              fail,
    input  logic [CSR_AW-1:0] csr_addr_in,
    output logic              status_vld,
    output logic [CODE_W-1:0] status_code,
    output logic              result_vld,
    output logic              result_fail,
    output logic              dump_vld,
    output logic [IDX_W-1:0]  dump_idx,
    output logic [DATA_W-1:0] dump_data,
    output logic              dump_done,
    output logic              csr_vld,
    output logic [CSR_AW-1:0] csr_addr,
    output logic [DATA_W-1:0] csr_data,
    output logic              err_pulse
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    seq_state_e        state_q;
    logic [IDX_W-1:0]  cnt_q;
    logic              last_word;

    // Flag the final word of a dump.
    always_comb begin
        last_word = (cnt_q == LAST_IDX);
    end

    // Advance the message state and payload counter on matching stores.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_HEADER;
            cnt_q   <= '0;
        end else if (hit) begin
            unique case (state_q)
                SQ_HEADER: begin
                    cnt_q <= '0;
                    if (kind == HK_DUMP)
                        state_q <= SQ_DUMP;
                    else if (kind == HK_CSR)
                        state_q <= SQ_CSR;
                end
                SQ_DUMP: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last_word)
                        state_q <= SQ_HEADER;
                end
                SQ_CSR: state_q <= SQ_HEADER;
                default: state_q <= SQ_HEADER;
            endcase
        end
    end

    // Produce the one-cycle event strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_vld <= 1'b0;
            result_vld <= 1'b0;
            dump_vld   <= 1'b0;
            dump_done  <= 1'b0;
            csr_vld    <= 1'b0;
            err_pulse  <= 1'b0;
        end else begin
            status_vld <= hit && (state_q == SQ_HEADER) && (kind == HK_STATUS);
            result_vld <= hit && (state_q == SQ_HEADER) && (kind == HK_RESULT);
            err_pulse  <= hit && (state_q == SQ_HEADER) && (kind == HK_BAD);
            dump_vld   <= hit && (state_q == SQ_DUMP);
            dump_done  <= hit && (state_q == SQ_DUMP) && last_word;
            csr_vld    <= hit && (state_q == SQ_CSR);
        end
    end

    // Capture the payload fields that travel with the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_code <= '0;
            result_fail <= 1'b0;
            dump_idx    <= '0;
            dump_data   <= '0;
            csr_addr    <= '0;
            csr_data    <= '0;
        end else if (hit) begin
            unique case (state_q)
                SQ_HEADER: begin
                    if (kind == HK_STATUS) status_code <= code;
                    if (kind == HK_RESULT) result_fail <= fail;
                    if (kind == HK_CSR)    csr_addr    <= csr_addr_in;
                end
                SQ_DUMP: begin
                    dump_idx  <= cnt_q;
                    dump_data <= wr_data;
                end
                SQ_CSR:  csr_data <= wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sig_write_decoder.sv
// Signature write decoder top: filters stores to the signature address,
// classifies headers and sequences multi-word messages into event strobes.
// Assumes DATA_W >= 20 and single-cycle store pulses.
module sig_write_decoder
    import sigdec_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] SIG_ADDR = 32'h8000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              status_vld,
    output logic [4:0]        status_code,
    output logic              result_vld,
    output logic              result_fail,
    output logic              dump_vld,
    output logic [4:0]        dump_idx,
    output logic [DATA_W-1:0] dump_data,
    output logic              dump_done,
    output logic              csr_vld,
    output logic [11:0]       csr_addr,
    output logic [DATA_W-1:0] csr_data,
    output logic              err_pulse
);
    logic              hit;
    hdr_kind_e         kind;
    logic [CODE_W-1:0] code;
    logic              fail;
    logic [CSR_AW-1:0] hdr_csr;

    sigdec_addr_match #(
        .ADDR_W   (ADDR_W),
        .SIG_ADDR (SIG_ADDR)
    ) u_match (
        .valid (wr_valid),
        .addr  (wr_addr),
        .hit   (hit)
    );

    sigdec_hdr_decode u_hdr (
        .hdr      (wr_data[HDR_USED_W-1:0]),
        .kind     (kind),
        .code     (code),
        .fail     (fail),
        .csr_addr (hdr_csr)
    );

    sigdec_seq #(
        .DATA_W (DATA_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .wr_data     (wr_data),
        .kind        (kind),
        .code        (code),
        .fail        (fail),
        .csr_addr_in (hdr_csr),
        .status_vld  (status_vld),
        .status_code (status_code),
        .result_vld  (result_vld),
        .result_fail (result_fail),
        .dump_vld    (dump_vld),
        .dump_idx    (dump_idx),
        .dump_data   (dump_data),
        .dump_done   (dump_done),
        .csr_vld     (csr_vld),
        .csr_addr    (csr_addr),
        .csr_data    (csr_data),
        .err_pulse   (err_pulse)
    );
endmodule

// File: rtl/sigdec_chk.sv
// Property checker for the signature write decoder, bound to the top.
// Assumes single-cycle store pulses sampled at the rising edge.
module sigdec_chk #(
    parameter int                ADDR_W   = 32,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] SIG_ADDR = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              status_vld,
    input logic [4:0]        status_code,
    input logic              result_vld,
    input logic              dump_vld,
    input logic [4:0]        dump_idx,
    input logic              dump_done,
    input logic              csr_vld,
    input logic [DATA_W-1:0] csr_data,
    input logic              err_pulse
);
    logic       in_dump_q;
    logic [4:0] last_idx_q;
    logic       hit;

    // Observe whether a dump is open and which index was last seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_dump_q  <= 1'b0;
            last_idx_q <= '0;
        end else if (dump_vld) begin
            in_dump_q  <= !dump_done;
            last_idx_q <= dump_idx;
        end
    end

    // Matching store seen by the checker.
    always_comb begin
        hit = wr_valid && (wr_addr == SIG_ADDR);
    end

    AST_EVENT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({status_vld, result_vld, dump_vld, csr_vld, err_pulse})); // R11
    AST_QUIET_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !(status_vld || result_vld || dump_vld || csr_vld || err_pulse)); // R9
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        status_vld |-> (status_code <= 5'd13) && (status_code == $past(wr_data[12:8]))); // R2
    AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        dump_done |-> dump_vld && (dump_idx == 5'd31)); // R5
    AST_DUMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dump_vld && in_dump_q) |-> (dump_idx == last_idx_q + 5'd1)); // R4
    AST_DUMP_START: assert property (@(posedge clk) disable iff (!rst_n)
        (dump_vld && !in_dump_q) |-> (dump_idx == 5'd0)); // R4
    AST_PAYLOAD_NO_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        in_dump_q |-> !(status_vld || result_vld || csr_vld || err_pulse)); // R10
    AST_CSR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        csr_vld |-> $past(hit) && (csr_data == $past(wr_data))); // R6
endmodule

bind sig_write_decoder sigdec_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SIG_ADDR (SIG_ADDR)
) i_sigdec_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .status_vld  (status_vld),
    .status_code (status_code),
    .result_vld  (result_vld),
    .dump_vld    (dump_vld),
    .dump_idx    (dump_idx),
    .dump_done   (dump_done),
    .csr_vld     (csr_vld),
    .csr_data    (csr_data),
    .err_pulse   (err_pulse)
);

// File: tb/test_sig_write_decoder.sv
`timescale 1ns/1ps
module test_sig_write_decoder;
    localparam logic [31:0] SIG   = 32'h8000_1000;
    localparam logic [31:0] OTHER = 32'h8000_1004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        status_vld, result_vld, result_fail, dump_vld, dump_done, csr_vld, err_pulse;
    logic [4:0]  status_code, dump_idx;
    logic [11:0] csr_addr;
    logic [31:0] dump_data, csr_data;

    int n_tests = 0;
    int n_fail  = 0;
    int n_dump_seen = 0;
    int n_done_seen = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    sig_write_decoder #(.ADDR_W(32), .DATA_W(32), .SIG_ADDR(SIG)) i_sig_write_decoder (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .status_vld(status_vld), .status_code(status_code),
        .result_vld(result_vld), .result_fail(result_fail),
        .dump_vld(dump_vld), .dump_idx(dump_idx), .dump_data(dump_data), .dump_done(dump_done),
        .csr_vld(csr_vld), .csr_addr(csr_addr), .csr_data(csr_data), .err_pulse(err_pulse)
    );

    // Reference model: expected outputs after each rising edge.
    int          m_mode = 0;   // 0 header, 1 dump, 2 csr
    int          m_cnt  = 0;
    logic [11:0] m_caddr = '0;
    logic        e_status, e_result, e_fail, e_dump, e_done, e_csr, e_err;
    logic [4:0]  e_code, e_idx;
    logic [11:0] e_caddr;
    logic [31:0] e_ddata, e_cdata;
    initial begin
        e_status = 0; e_result = 0; e_fail = 0; e_dump = 0; e_done = 0; e_csr = 0; e_err = 0;
        e_code = 0; e_idx = 0; e_caddr = 0; e_ddata = 0; e_cdata = 0;
    end

    always @(posedge clk) begin
        e_status = 0; e_result = 0; e_dump = 0; e_done = 0; e_csr = 0; e_err = 0;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0;
        end else if (wr_valid && wr_addr == SIG) begin
            if (m_mode == 1) begin
                e_dump = 1; e_idx = 5'(m_cnt); e_ddata = wr_data;
                m_cnt++;
                if (m_cnt == 32) begin e_done = 1; m_mode = 0; end
            end else if (m_mode == 2) begin
                e_csr = 1; e_caddr = m_caddr; e_cdata = wr_data; m_mode = 0;
            end else begin
                case (int'(wr_data[7:0]))
                    0: if (int'(wr_data[12:8]) <= 13) begin
                           e_status = 1; e_code = wr_data[12:8];
                       end else e_err = 1;
                    1: begin e_result = 1; e_fail = wr_data[8]; end
                    2: begin m_mode = 1; m_cnt = 0; end
                    3: begin m_mode = 2; m_caddr = wr_data[19:8]; end
                    default: e_err = 1;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Compare every output against the model away from the rising edge.
    always @(negedge clk) begin
        if (dump_vld) n_dump_seen++;
        if (dump_done) n_done_seen++;
        chk(status_vld === e_status, "R2", "status_vld", 32'(status_vld), 32'(e_status));
        if (e_status) chk(status_code === e_code, "R2", "status_code", 32'(status_code), 32'(e_code));
        chk(result_vld === e_result, "R3", "result_vld", 32'(result_vld), 32'(e_result));
        if (e_result) chk(result_fail === e_fail, "R3", "result_fail", 32'(result_fail), 32'(e_fail));
        chk(dump_vld === e_dump, "R4", "dump_vld", 32'(dump_vld), 32'(e_dump));
        if (e_dump) begin
            chk(dump_idx === e_idx, "R4", "dump_idx", 32'(dump_idx), 32'(e_idx));
            chk(dump_data === e_ddata, "R10", "dump_data", dump_data, e_ddata);
        end
        chk(dump_done === e_done, "R5", "dump_done", 32'(dump_done), 32'(e_done));
        chk(csr_vld === e_csr, "R6", "csr_vld", 32'(csr_vld), 32'(e_csr));
        if (e_csr) begin
            chk(csr_addr === e_caddr, "R6", "csr_addr", 32'(csr_addr), 32'(e_caddr));
            chk(csr_data === e_cdata, "R6", "csr_data", csr_data, e_cdata);
        end
        chk(err_pulse === e_err, "R7", "err_pulse", 32'(err_pulse), 32'(e_err));
    end

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
    endtask

    task automatic nop(input int n);
        wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL R11 watchdog actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    int base_d, base_n;

    initial begin
        @(negedge clk);
        nop(3);
        // R1: outputs cleared under reset
        chk(!(status_vld | result_vld | dump_vld | csr_vld | err_pulse | dump_done), "R1",
            "strobes in reset", 32'({status_vld, result_vld, dump_vld, csr_vld, err_pulse}), 0);
        rst_n = 1'b1;
        nop(2);

        // R2: every legal status code, R8: out-of-range codes
        for (int c = 0; c < 32; c++) wr(SIG, 32'hABC0_0000 | (32'(c) << 8));
        nop(2);
        // R3: verdicts with noise in unused bits
        wr(SIG, 32'h0000_0001); wr(SIG, 32'h0000_0101); wr(SIG, 32'hFFFF_FE01); nop(1);
        // R9: misses and valid-low stores carrying headers
        wr(OTHER, 32'h0000_0001); wr(OTHER, 32'h0000_0002);
        wr_valid = 1'b0; wr_addr = SIG; wr_data = 32'h0000_0004; @(negedge clk);
        nop(2);

        // R4, R5, R9, R10: dump with gaps, misses and header-like payload
        base_d = n_dump_seen; base_n = n_done_seen;
        wr(SIG, 32'h0000_0002);
        for (int r = 0; r < 32; r++) begin
            if (r % 5 == 1) wr(OTHER, 32'h0000_0000);
            if (r % 7 == 3) nop(1);
            wr(SIG, (r % 4 == 0) ? 32'(r % 4) + 32'h3 : 32'h1000_0000 + 32'(r));
        end
        nop(2);
        chk(n_dump_seen - base_d == 32, "R4", "dump word count", 32'(n_dump_seen - base_d), 32);
        chk(n_done_seen - base_n == 1, "R5", "dump done count", 32'(n_done_seen - base_n), 1);
        // R5: header accepted right after the dump
        wr(SIG, 32'h0000_0701); nop(1);

        // R6, R10: CSR header, a miss, then data shaped like a dump header
        wr(SIG, 32'h0034_1003); wr(OTHER, 32'h5); nop(1); wr(SIG, 32'h0000_0002); nop(2);
        wr(SIG, 32'h000F_FF03); wr(SIG, 32'hDEAD_BEEF); nop(1);

        // R7: illegal kinds, then normal traffic
        wr(SIG, 32'h0000_0004); wr(SIG, 32'h0000_00FF); wr(SIG, 32'h0000_0080);
        wr(SIG, 32'h0000_0300); nop(2);

        // R1: reset in the middle of a dump, then a status header
        wr(SIG, 32'h0000_0002);
        for (int r = 0; r < 5; r++) wr(SIG, 32'(r));
        rst_n = 1'b0; nop(2); rst_n = 1'b1;
        wr(SIG, 32'h0000_0500); nop(2);
        chk(n_done_seen - base_n == 1, "R1", "no done after reset", 32'(n_done_seen - base_n), 1);

        // R11: random mixed traffic, back to back
        for (int i = 0; i < 6000; i++) begin
            logic [31:0] d;
            d = $urandom;
            d[7:0] = 8'($urandom_range(0, 5));
            if ($urandom_range(0, 3) == 0) nop(1);
            else wr(($urandom_range(0, 4) == 0) ? OTHER : SIG, d);
        end
        nop(4);
        finish_run();
    end
endmodule